// File: doc/BRIEF.md
# Four-Channel Serial Controller Register Front End

This block is the host-facing register file of a four-channel serial controller. A simple 32-bit memory-mapped bus with one-cycle write and read strobes reaches a small global area and one 256-byte window per channel. The global area holds the interrupt status, the interrupt mask and the per-channel TX/RX enable pairs. Each channel window holds the CRC control word, the clock shift and divider, and the start and end addresses of the channel's TX and RX descriptor rings. A command register switches channels on and off. Which opcodes it accepts depends on a mode strap.

The ring engines raise one-cycle TX-done and RX-done pulses. These set bits in the interrupt status. A level interrupt output follows the masked status. It rises at once, but it falls only after several evaluations that find no masked source. Each channel also publishes a bit rate, derived from a base clock of 8 064 000 Hz by a shift and a divide. It publishes the starting current pointers of its two rings and a flag that selects a 4-byte CRC.

Top module: `mscc_regs`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `bus_rdata` is zero, and every `chan_on`, `tx_enable`, `rx_enable`, `crc_four` and `bit_rate` output is zero.
- R2: Interrupt status (global offset 0x00, 8 bits) sets bit n on a `tx_done_evt[n]` pulse and bit 4+n on a `rx_done_evt[n]` pulse. A write clears exactly the bits written as 1. An event arriving in the same cycle as a clearing write leaves its bit set.
- R3: Interrupt mask (0x10, 8 bits) and channel enable (0x14, 8 bits) read back what was written. Enable bit 2n drives `tx_enable[n]` and bit 2n+1 drives `rx_enable[n]`.
- R4: Any event pulse, status write or mask write triggers a re-evaluation. If status AND mask is then nonzero, `irq` is high from the next clock edge.
- R5: A re-evaluation that finds status AND mask equal to zero advances a counter. `irq` falls only on the re-evaluation that brings this counter to 3, and the counter then restarts at zero. Re-evaluations that raise `irq` leave the counter as it is.
- R6: Channel n (0..3) decodes at address (n+1)*0x100. Inside the window, CRC control is at 0x00, clock shift (4 bits) at 0x40, divider (8 bits) at 0x44, TX start and end at 0x80 and 0x84, and RX start and end at 0x88 and 0x8C. All of them read back.
- R7: A write to TX start (RX start) also loads `tx_cur_ptr` (`rx_cur_ptr`) of that channel with the written value. Writes to the end registers leave the current pointers unchanged.
- R8: Writing CRC control with 0x0A sets `crc_four[n]` (4-byte CRC). Writing 0x08 or any other value clears it (2-byte CRC).
- R9: On every read or write of the clock-shift register, the channel's `bit_rate` (23 bits) becomes (8064000 >> s) / (divider + 1). Here s is the shift, taken from the written data on a write, and a shift of 8 counts as 0. A divider write alone does not change `bit_rate`.
- R10: A write to 0x2C24 carries an opcode in bits 19:12 and a channel id in bits 1:0. Opcode 0x00 sets `chan_on[id]`. With `mode_sel`=0, opcode 0x10 clears it. With `mode_sel`=1, opcodes 0x30 and 0x50 clear it. Every other opcode leaves `chan_on` unchanged.
- R11: Address 0x2C2C reads 0x0000FFFF. Channel offset 0x64 reads 0x7B and channel offset 0x90 reads 0x11111111.
- R12: Addresses not listed above, the command register included, read zero. Writes to them change no register and no output.
- R13: `bus_rdata` takes the addressed value at the clock edge that samples `bus_rd`. It holds that value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Strap selecting the command opcode set |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_done_evt | input | 4 | TX completion pulse per channel |
| rx_done_evt | input | 4 | RX completion pulse per channel |
| irq | output | 1 | Level interrupt |
| chan_on | output | 4 | Channel enabled by command |
| tx_enable | output | 4 | TX enable per channel |
| rx_enable | output | 4 | RX enable per channel |
| crc_four | output | 4 | 4-byte CRC selected per channel |
| bit_rate | output | 92 | Four 23-bit channel rates, channel n at [23n +: 23] |
| tx_cur_ptr | output | 128 | Four 32-bit TX current pointers |
| rx_cur_ptr | output | 128 | Four 32-bit RX current pointers |

## Verification
Some properties are checked on every cycle. A live masked source always implies a high interrupt. The clear counter never passes two, and the line falls only when that counter stood at two. Cleared bits stay cleared unless an event arrives, and event bits always land. Start writes load the current pointers, and the rate holds between clock-shift accesses. Unknown command opcodes leave the channel state alone, read data holds between reads, and reads of unmapped space return zero. Other behaviours need the directed scenarios. These are the exact count of evaluations before the line falls, with the counter carried across assertions. The bench also covers set-over-clear in one cycle, the rate arithmetic including shift 8, and the mode-dependent disable opcodes. Last come the constant registers and the way the enable pairs split.

// File: rtl/mscc_pkg.sv
package mscc_pkg;

  typedef enum logic [1:0] {CMD_NOP, CMD_ON, CMD_OFF} cmd_act_e;

  localparam logic [7:0]  G_STATUS   = 8'h00;
  localparam logic [7:0]  G_MASK     = 8'h10;
  localparam logic [7:0]  G_ENABLE   = 8'h14;
  localparam logic [13:0] A_COMMAND  = 14'h2C24;
  localparam logic [13:0] A_RESPONSE = 14'h2C2C;

  localparam logic [7:0] C_CRC    = 8'h00;
  localparam logic [7:0] C_SHIFT  = 8'h40;
  localparam logic [7:0] C_DIV    = 8'h44;
  localparam logic [7:0] C_PORTST = 8'h64;
  localparam logic [7:0] C_TXBEG  = 8'h80;
  localparam logic [7:0] C_TXLIM  = 8'h84;
  localparam logic [7:0] C_RXBEG  = 8'h88;
  localparam logic [7:0] C_RXLIM  = 8'h8C;
  localparam logic [7:0] C_CLKINF = 8'h90;

  // rate = (base >> shift) / (div + 1), shift 8 folded to 0
  function automatic logic [31:0] rate_of(input logic [31:0] base,
                                          input logic [7:0]  shift,
                                          input logic [15:0] div);
    logic [7:0]  s;
    logic [31:0] num;
    s   = (shift == 8'd8) ? 8'd0 : shift;
    num = (s >= 8'd32) ? 32'd0 : (base >> s);
    return num / ({16'd0, div} + 32'd1);
  endfunction

  function automatic logic crc_is_four(input logic [31:0] ctrl);
    return ctrl == 32'h0000_000A;
  endfunction

  function automatic cmd_act_e decode_cmd(input logic mode, input logic [7:0] op);
    if (op == 8'h00) return CMD_ON;
    if (!mode && op == 8'h10) return CMD_OFF;
    if (mode && (op == 8'h30 || op == 8'h50)) return CMD_OFF;
    return CMD_NOP;
  endfunction

endpackage

// File: rtl/mscc_irq.sv
module mscc_irq #(
  parameter int NCH       = 4,
  parameter int CLR_EVALS = 3,
  localparam int ST_W     = 2 * NCH,
  localparam int CNT_W    = $clog2(CLR_EVALS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  tx_evt,
  input  logic [NCH-1:0]  rx_evt,
  input  logic            st_clr_wr,
  input  logic            mask_wr,
  input  logic [ST_W-1:0] wdata,
  output logic [ST_W-1:0] status,
  output logic [ST_W-1:0] mask,
  output logic            irq
);

  logic [ST_W-1:0]  set_bits, st_nx, mk_nx;
  logic             reeval, live_nx;
  logic [CNT_W-1:0] clr_cnt;

  assign set_bits = {rx_evt, tx_evt};
  assign reeval   = (|set_bits) | st_clr_wr | mask_wr;
  assign st_nx    = (status & ~(st_clr_wr ? wdata : '0)) | set_bits;
  assign mk_nx    = mask_wr ? wdata : mask;
  assign live_nx  = |(st_nx & mk_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      mask    <= '0;
      irq     <= 1'b0;
      clr_cnt <= '0;
    end else begin
      status <= st_nx;
      mask   <= mk_nx;
      if (reeval) begin
        if (live_nx) begin
          irq <= 1'b1;
        end else if (clr_cnt == CNT_W'(CLR_EVALS - 1)) begin
          irq     <= 1'b0;
          clr_cnt <= '0;
        end else begin
          clr_cnt <= clr_cnt + 1'b1;
        end
      end
    end
  end

  // R4: a live masked source always has the line up
  p_irq_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & mask)) |-> irq);

  // R5: the line only falls when the counter sat at its last step
  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(clr_cnt) == CNT_W'(CLR_EVALS - 1)));

  // R5: counter stays below the clear threshold
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt < CNT_W'(CLR_EVALS));

  // R2: cleared bits are gone unless an event came along
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr_wr && !(|set_bits)) |=> ((status & $past(wdata)) == '0));

  // R2: every event lands in status
  p_evt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((status & $past(set_bits)) == $past(set_bits)));

endmodule

// File: rtl/mscc_chan.sv
module mscc_chan
  import mscc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 4,
  parameter int DIV_W   = 8,
  parameter int BASE_HZ = 8064000,
  localparam int RATE_W = $clog2(BASE_HZ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        off,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              crc_four_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [ADDR_W-1:0] tx_cur_o,
  output logic [ADDR_W-1:0] rx_cur_o
);

  logic [31:0]        crc_ctrl;
  logic [SHIFT_W-1:0] shift_q, shift_eff;
  logic [DIV_W-1:0]   div_q;
  logic [ADDR_W-1:0]  tx_beg, tx_lim, rx_beg, rx_lim;
  logic               wr_at, clk_touch;

  assign wr_at     = hit & wr;
  assign clk_touch = hit & (wr | rd) & (off == C_SHIFT);
  assign shift_eff = wr ? wdata[SHIFT_W-1:0] : shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_ctrl   <= '0;
      crc_four_o <= 1'b0;
      shift_q    <= '0;
      div_q      <= '0;
      tx_beg     <= '0;
      tx_lim     <= '0;
      rx_beg     <= '0;
      rx_lim     <= '0;
      tx_cur_o   <= '0;
      rx_cur_o   <= '0;
      rate_o     <= '0;
    end else begin
      if (wr_at) begin
        case (off)
          C_CRC: begin
            crc_ctrl   <= wdata;
            crc_four_o <= crc_is_four(wdata);
          end
          C_SHIFT: shift_q <= wdata[SHIFT_W-1:0];
          C_DIV:   div_q   <= wdata[DIV_W-1:0];
          C_TXBEG: begin
            tx_beg   <= wdata[ADDR_W-1:0];
            tx_cur_o <= wdata[ADDR_W-1:0];
          end
          C_TXLIM: tx_lim <= wdata[ADDR_W-1:0];
          C_RXBEG: begin
            rx_beg   <= wdata[ADDR_W-1:0];
            rx_cur_o <= wdata[ADDR_W-1:0];
          end
          C_RXLIM: rx_lim <= wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (clk_touch)
        rate_o <= RATE_W'(rate_of(BASE_HZ, 8'(shift_eff), 16'(div_q)));
    end
  end

  always_comb begin
    case (off)
      C_CRC:    rdata = crc_ctrl;
      C_SHIFT:  rdata = 32'(shift_q);
      C_DIV:    rdata = 32'(div_q);
      C_PORTST: rdata = 32'h0000_007B;
      C_TXBEG:  rdata = 32'(tx_beg);
      C_TXLIM:  rdata = 32'(tx_lim);
      C_RXBEG:  rdata = 32'(rx_beg);
      C_RXLIM:  rdata = 32'(rx_lim);
      C_CLKINF: rdata = 32'h1111_1111;
      default:  rdata = 32'h0;
    endcase
  end

  // R7: a start write loads the current pointer
  p_txcur_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_at && off == C_TXBEG) |=> (tx_cur_o == $past(wdata[ADDR_W-1:0])));
  p_rxcur_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_at && off == C_RXBEG) |=> (rx_cur_o == $past(wdata[ADDR_W-1:0])));

  // R9: the rate moves only on a clock-shift access
  p_rate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_touch |=> $stable(rate_o));

endmodule

// File: rtl/mscc_cmd.sv
module mscc_cmd
  import mscc_pkg::*;
#(
  parameter int NCH = 4,
  localparam int ID_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode,
  input  logic            cmd_wr,
  input  logic [7:0]      opcode,
  input  logic [ID_W-1:0] chan_id,
  output logic [NCH-1:0]  chan_on
);

  cmd_act_e act;
  logic     id_ok;

  assign act   = decode_cmd(mode, opcode);
  assign id_ok = 32'(chan_id) < NCH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_on <= '0;
    end else if (cmd_wr && id_ok) begin
      case (act)
        CMD_ON:  chan_on[chan_id] <= 1'b1;
        CMD_OFF: chan_on[chan_id] <= 1'b0;
        default: ;
      endcase
    end
  end

  // R10: opcodes outside the known set never move channel state
  p_cmd_unknown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && opcode != 8'h00 && opcode != 8'h10 && opcode != 8'h30 && opcode != 8'h50)
      |=> $stable(chan_on));

  // R10: one command touches at most one channel
  p_cmd_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_on ^ $past(chan_on)) <= 1);

endmodule

// File: rtl/mscc_regs.sv
module mscc_regs
  import mscc_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int ADDR_W    = 32,
  parameter int SHIFT_W   = 4,
  parameter int DIV_W     = 8,
  parameter int BASE_HZ   = 8064000,
  parameter int CLR_EVALS = 3,
  localparam int RATE_W   = $clog2(BASE_HZ + 1),
  localparam int ST_W     = 2 * NCH,
  localparam int ID_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_sel,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [13:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NCH-1:0]          tx_done_evt,
  input  logic [NCH-1:0]          rx_done_evt,
  output logic                    irq,
  output logic [NCH-1:0]          chan_on,
  output logic [NCH-1:0]          tx_enable,
  output logic [NCH-1:0]          rx_enable,
  output logic [NCH-1:0]          crc_four,
  output logic [NCH*RATE_W-1:0]   bit_rate,
  output logic [NCH*ADDR_W-1:0]   tx_cur_ptr,
  output logic [NCH*ADDR_W-1:0]   rx_cur_ptr
);

  logic            glb;
  logic            st_clr_wr, mask_wr, en_wr, cmd_wr;
  logic [ST_W-1:0] status, mask, en_mask;
  logic [NCH-1:0]  ch_hit;
  logic [31:0]     ch_rdata [NCH];
  logic [31:0]     rd_mux;

  assign glb       = bus_addr[13:8] == 6'd0;
  assign st_clr_wr = bus_wr & glb & (bus_addr[7:0] == G_STATUS);
  assign mask_wr   = bus_wr & glb & (bus_addr[7:0] == G_MASK);
  assign en_wr     = bus_wr & glb & (bus_addr[7:0] == G_ENABLE);
  assign cmd_wr    = bus_wr & (bus_addr == A_COMMAND);

  mscc_irq #(.NCH(NCH), .CLR_EVALS(CLR_EVALS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_evt    (tx_done_evt),
    .rx_evt    (rx_done_evt),
    .st_clr_wr (st_clr_wr),
    .mask_wr   (mask_wr),
    .wdata     (bus_wdata[ST_W-1:0]),
    .status    (status),
    .mask      (mask),
    .irq       (irq)
  );

  mscc_cmd #(.NCH(NCH)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_sel),
    .cmd_wr  (cmd_wr),
    .opcode  (bus_wdata[19:12]),
    .chan_id (bus_wdata[ID_W-1:0]),
    .chan_on (chan_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     en_mask <= '0;
    else if (en_wr) en_mask <= bus_wdata[ST_W-1:0];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ch_hit[n]    = bus_addr[13:8] == 6'(n + 1);
    assign tx_enable[n] = en_mask[2*n];
    assign rx_enable[n] = en_mask[2*n+1];

    mscc_chan #(
      .ADDR_W (ADDR_W), .SHIFT_W(SHIFT_W), .DIV_W(DIV_W), .BASE_HZ(BASE_HZ)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (ch_hit[n]),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .off        (bus_addr[7:0]),
      .wdata      (bus_wdata),
      .rdata      (ch_rdata[n]),
      .crc_four_o (crc_four[n]),
      .rate_o     (bit_rate[n*RATE_W +: RATE_W]),
      .tx_cur_o   (tx_cur_ptr[n*ADDR_W +: ADDR_W]),
      .rx_cur_o   (rx_cur_ptr[n*ADDR_W +: ADDR_W])
    );
  end

  always_comb begin
    rd_mux = 32'h0;
    if (glb) begin
      case (bus_addr[7:0])
        G_STATUS: rd_mux = 32'(status);
        G_MASK:   rd_mux = 32'(mask);
        G_ENABLE: rd_mux = 32'(en_mask);
        default:  rd_mux = 32'h0;
      endcase
    end else if (bus_addr == A_RESPONSE) begin
      rd_mux = 32'h0000_FFFF;
    end
    for (int n = 0; n < NCH; n++)
      if (ch_hit[n]) rd_mux = ch_rdata[n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R13: read data holds while no read is issued
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R12: the gap between channel windows and the response register reads zero
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= 14'h0500 && bus_addr < 14'h2C00) |=> (bus_rdata == 32'h0));

endmodule

// File: tb/mscc_regs_bench.sv
`timescale 1ns/1ps
module mscc_regs_bench;

  localparam int NCH = 4;
  localparam int RW  = 23;
  localparam int BASE = 8064000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_sel = 1'b0;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [13:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NCH-1:0]   tx_done_evt = '0, rx_done_evt = '0;
  logic             irq;
  logic [NCH-1:0]   chan_on, tx_enable, rx_enable, crc_four;
  logic [NCH*RW-1:0] bit_rate;
  logic [NCH*32-1:0] tx_cur_ptr, rx_cur_ptr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mscc_regs u_mscc_regs (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_done_evt(tx_done_evt), .rx_done_evt(rx_done_evt),
    .irq(irq), .chan_on(chan_on), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .crc_four(crc_four), .bit_rate(bit_rate),
    .tx_cur_ptr(tx_cur_ptr), .rx_cur_ptr(rx_cur_ptr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] t, input logic [3:0] r);
    @(negedge clk);
    tx_done_evt = t; rx_done_evt = r;
    @(negedge clk);
    tx_done_evt = '0; rx_done_evt = '0;
  endtask

  function automatic logic [31:0] exp_rate(input int s, input int d);
    int sh;
    sh = (s == 8) ? 0 : s;
    return 32'((BASE / (2 ** sh)) / (d + 1));
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 rdata", bus_rdata, 0);
    check("R1 outputs", {16'd0, chan_on, tx_enable, rx_enable, crc_four}, 0);
    check("R1 rate", bit_rate[31:0], 0);
    rd(14'h000, v); check("R1 status", v, 0);
    rd(14'h180, v); check("R1 tx start", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    do_reset();
    wr(14'h010, 32'h11);              // eval 1, zero
    check("R4 masked idle", {31'd0, irq}, 0);
    pulse(4'b0001, 4'b0000);
    check("R4 tx evt raises", {31'd0, irq}, 1);
    rd(14'h000, v); check("R2 tx bit n", v, 32'h01);
    pulse(4'b0000, 4'b0100);
    rd(14'h000, v); check("R2 rx bit 4+n", v, 32'h41);
    wr(14'h000, 32'h41);              // eval 2, zero
    check("R5 held after clear", {31'd0, irq}, 1);
    rd(14'h000, v); check("R2 w1c", v, 0);
    wr(14'h010, 32'h11);              // eval 3, falls
    check("R5 third eval drops", {31'd0, irq}, 0);
    pulse(4'b0010, 4'b0000);          // masked off, cnt 1
    check("R4 masked source quiet", {31'd0, irq}, 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 14'h000; bus_wdata = 32'h02; tx_done_evt = 4'b0010;
    @(negedge clk);
    bus_wr = 1'b0; tx_done_evt = '0;  // cnt 2
    rd(14'h000, v); check("R2 set beats clear", v, 32'h02);
    pulse(4'b0000, 4'b0001);
    check("R4 rx evt raises", {31'd0, irq}, 1);
    wr(14'h000, 32'h12);              // cnt reaches 3
    check("R5 carried count drops", {31'd0, irq}, 0);
    pulse(4'b0000, 4'b0001);
    wr(14'h000, 32'h10);
    check("R5 one eval held", {31'd0, irq}, 1);
    wr(14'h010, 32'h11);
    check("R5 two evals held", {31'd0, irq}, 1);
    wr(14'h010, 32'h11);
    check("R5 three evals drop", {31'd0, irq}, 0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(14'h014, 32'h2D);
    rd(14'h014, v); check("R3 enable readback", v, 32'h2D);
    check("R3 tx_enable", {28'd0, tx_enable}, 32'h3);
    check("R3 rx_enable", {28'd0, rx_enable}, 32'h6);
    wr(14'h010, 32'hFFA5);
    rd(14'h010, v); check("R3 mask readback", v, 32'hA5);
  endtask

  task automatic t_chan();
    logic [31:0] v;
    for (int n = 0; n < NCH; n++) begin
      logic [13:0] b;
      b = 14'((n + 1) * 256);
      wr(b + 14'h80, 32'h1000_0000 + 32'(n));
      wr(b + 14'h84, 32'h2000_0000 + 32'(n));
      wr(b + 14'h88, 32'h3000_0000 + 32'(n));
      wr(b + 14'h8C, 32'h4000_0000 + 32'(n));
      rd(b + 14'h80, v); check("R6 tx start", v, 32'h1000_0000 + 32'(n));
      rd(b + 14'h84, v); check("R6 tx end", v, 32'h2000_0000 + 32'(n));
      rd(b + 14'h88, v); check("R6 rx start", v, 32'h3000_0000 + 32'(n));
      rd(b + 14'h8C, v); check("R6 rx end", v, 32'h4000_0000 + 32'(n));
      check("R7 tx cur", tx_cur_ptr[n*32 +: 32], 32'h1000_0000 + 32'(n));
      check("R7 rx cur", rx_cur_ptr[n*32 +: 32], 32'h3000_0000 + 32'(n));
    end
    wr(14'h184, 32'h5555_0000);
    check("R7 end keeps cur", tx_cur_ptr[31:0], 32'h1000_0000);
    wr(14'h144, 32'h7);
    rd(14'h144, v); check("R6 divider", v, 32'h7);
  endtask

  task automatic t_crc();
    logic [31:0] v;
    wr(14'h300, 32'h08); check("R8 0x08 two", {28'd0, crc_four}, 0);
    wr(14'h300, 32'h0A); check("R8 0x0A four", {28'd0, crc_four}, 32'h4);
    wr(14'h300, 32'h09); check("R8 other two", {28'd0, crc_four}, 0);
    rd(14'h300, v); check("R6 crc readback", v, 32'h09);
  endtask

  task automatic t_rate();
    logic [31:0] v;
    wr(14'h144, 32'd3);
    wr(14'h140, 32'd0);
    check("R9 shift0 div3", 32'(bit_rate[0 +: RW]), exp_rate(0, 3));
    wr(14'h140, 32'd8);
    check("R9 shift8 as 0", 32'(bit_rate[0 +: RW]), exp_rate(8, 3));
    rd(14'h140, v); check("R6 shift readback", v, 32'd8);
    wr(14'h140, 32'd2);
    check("R9 shift2", 32'(bit_rate[0 +: RW]), exp_rate(2, 3));
    wr(14'h144, 32'd0);
    check("R9 div write alone", 32'(bit_rate[0 +: RW]), exp_rate(2, 3));
    rd(14'h140, v);
    check("R9 read recomputes", 32'(bit_rate[0 +: RW]), exp_rate(2, 0));
    wr(14'h444, 32'd6);
    wr(14'h440, 32'd5);
    check("R9 ch3 rate", 32'(bit_rate[3*RW +: RW]), exp_rate(5, 6));
  endtask

  task automatic t_cmd();
    mode_sel = 1'b0;
    wr(14'h2C24, 32'h0_0001);
    check("R10 enable", {28'd0, chan_on}, 32'h2);
    wr(14'h2C24, 32'h3_0001);
    check("R10 mode0 ignores 0x30", {28'd0, chan_on}, 32'h2);
    wr(14'h2C24, 32'h1_0001);
    check("R10 mode0 0x10 off", {28'd0, chan_on}, 0);
    mode_sel = 1'b1;
    wr(14'h2C24, 32'h0_0003);
    wr(14'h2C24, 32'h1_0003);
    check("R10 mode1 ignores 0x10", {28'd0, chan_on}, 32'h8);
    wr(14'h2C24, 32'h5_0003);
    check("R10 mode1 0x50 off", {28'd0, chan_on}, 0);
    wr(14'h2C24, 32'h0_0003);
    wr(14'h2C24, 32'h3_0003);
    check("R10 mode1 0x30 off", {28'd0, chan_on}, 0);
    mode_sel = 1'b0;
  endtask

  task automatic t_const();
    logic [31:0] v;
    rd(14'h2C2C, v); check("R11 response", v, 32'hFFFF);
    rd(14'h164, v);  check("R11 port status", v, 32'h7B);
    rd(14'h490, v);  check("R11 clock info", v, 32'h1111_1111);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(14'h020, 32'hFFFF_FFFF);
    wr(14'h0504, 32'hFFFF_FFFF);
    wr(14'h1A0, 32'hFFFF_FFFF);
    rd(14'h020, v);  check("R12 global gap", v, 0);
    rd(14'h0504, v); check("R12 past windows", v, 0);
    rd(14'h1A0, v);  check("R12 window gap", v, 0);
    rd(14'h3000, v); check("R12 high", v, 0);
    rd(14'h2C24, v); check("R12 command reads 0", v, 0);
    rd(14'h010, v);  check("R12 mask untouched", v, 32'hA5);
    check("R12 outputs untouched", {16'd0, chan_on, tx_enable, rx_enable, crc_four}, 32'h0360);
  endtask

  task automatic t_rdlat();
    logic [31:0] v;
    rd(14'h014, v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 14'h2C2C;
    #1 check("R13 not before edge", bus_rdata, 32'h2D);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 14'h014;
    check("R13 after edge", bus_rdata, 32'hFFFF);
    repeat (3) @(negedge clk);
    check("R13 holds", bus_rdata, 32'hFFFF);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_irq();
    t_masks();
    t_chan();
    t_crc();
    t_rate();
    t_cmd();
    t_const();
    t_unmapped();
    t_rdlat();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule